// File: doc/BRIEF.md
# Data-Ready Strobe Generator

The block turns a master clock into the timing of a sampling converter. A prescaler divides the master clock by a power of two to form the modulator clock. A second counter divides the modulator clock by the oversampling ratio, which sets the length of one conversion period. Once per conversion period the block drives a data-ready strobe. The strobe is a pulse, not a flag, so nothing has to clear it. It is active low and lasts exactly one modulator-clock period, placed in the last modulator slot of the period.

The output pin is described by a drive value and an output enable. In push-pull mode the pin is driven at all times. In released-idle mode it is driven only while the strobe is low, and an external pull-up holds the idle level. The strobe runs on its own and does not depend on any serial traffic. A new divide setting waits for the end of the current conversion period, so no pulse is ever cut short or repeated.

Top module: `dready_pulse_gen`

## Requirements
- R1: The modulator clock period is P master-clock cycles, with P = 1, 2, 4 or 8 for `preSel` = 0, 1, 2 or 3.
- R2: Strobes repeat every P*N master-clock cycles, with N = 32, 64, 128 or 256 for `osrSel` = 0, 1, 2 or 3.
- R3: Each strobe holds `readyOut` low for exactly P consecutive master-clock cycles, which is one modulator period. This is the last modulator slot of the conversion period.
- R4: The strobe is not latched. `readyOut` goes back high by itself after P cycles, with no acknowledge input.
- R5: With `hizIdleN` = 0 (released idle), `readyOe` is 1 only while `readyOut` is 0. With `hizIdleN` = 1 (push-pull), `readyOe` is 1 on every cycle after reset.
- R6: While `rstN` is low, `readyOut` = 1 and `readyOe` = 0 (pin released), and both dividers are cleared.
- R7: A change of `preSel` or `osrSel` is sampled only at the clock edge that ends a conversion period. The pulse already under way keeps its old width and period.
- R8: The first conversion period starts at the first rising clock edge with `rstN` high. The settings are sampled at that edge, and the first strobe begins P*N - P cycles after it.
- R9: `hizIdleN` takes effect on `readyOe` in the same cycle it changes. It does not wait for a period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| preSel | input | 2 | Prescale select: divide by 2^preSel |
| osrSel | input | 2 | Oversampling select: ratio 2^(osrSel+5) |
| hizIdleN | input | 1 | 1 = push-pull, 0 = pin released when idle |
| readyOut | output | 1 | Data-ready drive value, active low |
| readyOe | output | 1 | Output enable for the data-ready pin |

## Verification
The divide path is run at the smallest setting (1x32), at the largest (8x256) and at mixed pairs (2x32, 4x64). These show whether a wrong width comes from the prescaler or from the oversampling counter. Two further checks look at the counters from reset: the offset of the first strobe after reset release catches an off-by-one start, and a setting change in the middle of a period tells deferred loading apart from immediate loading. The output mode is switched both in idle and during pulses, which separates the enable logic from the drive value. A reset that arrives in the middle of a strobe shows whether the pin is released at once.

// File: rtl/drs_pkg.sv
package drs_pkg;
  // Sequencing strobes sent from the control to the datapath
  typedef struct packed {
    logic run;   // counting is active (after the first edge out of reset)
    logic load;  // first edge out of reset: sample settings, start a period
    logic tick;  // last master cycle of a modulator period
  } seqStrobe_t;
endpackage

// File: rtl/drs_ctrl.sv
module drs_ctrl
  import drs_pkg::*;
#(
  parameter int PRE_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PRE_SEL_W-1:0] activePre,
  output seqStrobe_t           strobe
);
  // Largest prescale is 2^(2^PRE_SEL_W - 1); its counter needs that many bits
  localparam int PRE_CNT_W = (1 << PRE_SEL_W) - 1;

  logic                 started;
  logic [PRE_CNT_W-1:0] preCnt;
  logic [PRE_CNT_W-1:0] preLast;

  // preLast = 2^activePre - 1, formed as a low-order mask
  always_comb begin
    for (int i = 0; i < PRE_CNT_W; i++) begin
      preLast[i] = (i < int'(activePre));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started <= 1'b0;
      preCnt  <= '0;
    end else begin
      started <= 1'b1;
      if (!started || (preCnt == preLast)) preCnt <= '0;
      else                                 preCnt <= preCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.run  = started;
    strobe.load = !started;
    strobe.tick = started && (preCnt == preLast);
  end

  // R1: after a modulator tick the prescaler restarts from zero
  p_prescale_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tick |=> (preCnt == '0));

  // R1: the prescaler never runs past its limit
  p_prescale_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preLast);
endmodule

// File: rtl/drs_datapath.sv
module drs_datapath
  import drs_pkg::*;
#(
  parameter int PRE_SEL_W     = 2,
  parameter int OSR_SEL_W     = 2,
  parameter int OSR_BASE_LOG2 = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PRE_SEL_W-1:0] preSel,
  input  logic [OSR_SEL_W-1:0] osrSel,
  input  logic                 hizIdleN,
  input  seqStrobe_t           strobe,
  output logic [PRE_SEL_W-1:0] activePre,
  output logic                 readyOut,
  output logic                 readyOe
);
  localparam int OSR_CNT_W = OSR_BASE_LOG2 + (1 << OSR_SEL_W) - 1;

  logic [OSR_SEL_W-1:0] activeOsr;
  logic [OSR_CNT_W-1:0] osrCnt;
  logic [OSR_CNT_W-1:0] osrInc;
  logic [OSR_CNT_W-1:0] osrLast;
  logic                 frameEnd;
  logic                 pulseQ;

  // osrLast = 2^(activeOsr + base) - 1
  always_comb begin
    for (int i = 0; i < OSR_CNT_W; i++) begin
      osrLast[i] = (i < OSR_BASE_LOG2 + int'(activeOsr));
    end
  end

  assign osrInc   = osrCnt + 1'b1;
  assign frameEnd = strobe.tick && (osrCnt == osrLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activePre <= '0;
      activeOsr <= '0;
      osrCnt    <= '0;
      pulseQ    <= 1'b0;
    end else if (strobe.load) begin
      activePre <= preSel;
      activeOsr <= osrSel;
      osrCnt    <= '0;
      pulseQ    <= 1'b0;
    end else if (strobe.tick) begin
      if (frameEnd) begin
        activePre <= preSel;
        activeOsr <= osrSel;
        osrCnt    <= '0;
        pulseQ    <= 1'b0;
      end else begin
        osrCnt <= osrInc;
        pulseQ <= (osrInc == osrLast);
      end
    end
  end

  assign readyOut = !pulseQ;
  assign readyOe  = strobe.run && (hizIdleN || pulseQ);

  // R3: the strobe occupies only the last modulator slot of a period
  p_pulse_last_slot_r3: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |-> (osrCnt == osrLast));

  // R4: the strobe ends on its own at the period boundary
  p_pulse_self_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pulseQ && frameEnd) |=> !pulseQ);

  // R7: active settings change only at a period boundary or the start
  p_setting_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((activeOsr != $past(activeOsr)) || (activePre != $past(activePre)))
      |-> $past(frameEnd || strobe.load));
endmodule

// File: rtl/dready_pulse_gen.sv
module dready_pulse_gen
  import drs_pkg::*;
#(
  parameter int PRE_SEL_W     = 2,
  parameter int OSR_SEL_W     = 2,
  parameter int OSR_BASE_LOG2 = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PRE_SEL_W-1:0] preSel,
  input  logic [OSR_SEL_W-1:0] osrSel,
  input  logic                 hizIdleN,
  output logic                 readyOut,
  output logic                 readyOe
);
  seqStrobe_t           strobe;
  logic [PRE_SEL_W-1:0] activePre;

  drs_ctrl #(.PRE_SEL_W(PRE_SEL_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .activePre (activePre),
    .strobe    (strobe)
  );

  drs_datapath #(
    .PRE_SEL_W     (PRE_SEL_W),
    .OSR_SEL_W     (OSR_SEL_W),
    .OSR_BASE_LOG2 (OSR_BASE_LOG2)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .preSel    (preSel),
    .osrSel    (osrSel),
    .hizIdleN  (hizIdleN),
    .strobe    (strobe),
    .activePre (activePre),
    .readyOut  (readyOut),
    .readyOe   (readyOe)
  );

  // R6: pin released and high while reset is held
  p_reset_idle_r6: assert property (@(posedge clk)
    !rstN |-> (readyOut && !readyOe));

  // R5: in released-idle mode the pin is never driven while high
  p_hiz_idle_released_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!hizIdleN && readyOut) |-> !readyOe);
endmodule

// File: tb/dready_pulse_gen_bench.sv
module dready_pulse_gen_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] preSel = 2'd0;
  logic [1:0] osrSel = 2'd0;
  logic       hizIdleN = 1'b1;
  logic       readyOut, readyOe;

  always #5 clk = ~clk;

  dready_pulse_gen u_dready_pulse_gen (
    .clk(clk), .rstN(rstN), .preSel(preSel), .osrSel(osrSel),
    .hizIdleN(hizIdleN), .readyOut(readyOut), .readyOe(readyOe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: position inside the current period
  bit mStarted = 0;
  int mP = 1, mL = 32, mPos = 0;
  always @(posedge clk) begin
    if (!rstN) mStarted = 0;
    else if (!mStarted) begin
      mStarted = 1; mP = 1 << preSel; mL = mP * (32 << osrSel); mPos = 0;
    end else begin
      mPos++;
      if (mPos == mL) begin
        mPos = 0; mP = 1 << preSel; mL = mP * (32 << osrSel);
      end
    end
  end

  // Per-cycle compare plus pulse measurements
  int  cyc = 0, relCyc = 0, fallCount = 0, lastFall = 0, firstFall = 0;
  int  lastWidth = 0, lastPeriod = 0;
  bit  seenRel = 0, prevOut = 1;
  always @(negedge clk) begin
    bit expOut, expOe;
    cyc++;
    if (!rstN) begin
      check(readyOut === 1'b1, "R6", "readyOut in reset", int'(readyOut), 1);
      check(readyOe === 1'b0, "R6", "readyOe in reset", int'(readyOe), 0);
      seenRel = 0; fallCount = 0; prevOut = 1;
    end else begin
      if (!seenRel) begin seenRel = 1; relCyc = cyc; end
      expOut = !(mStarted && (mPos >= mL - mP));
      expOe  = mStarted && (hizIdleN || !expOut);
      check(readyOut === expOut, expOut ? "R4" : "R3", "readyOut vs model",
            int'(readyOut), int'(expOut));
      check(readyOe === expOe, "R5", "readyOe vs model", int'(readyOe), int'(expOe));
      if (prevOut && !readyOut) begin
        if (fallCount == 0) firstFall = cyc;
        else lastPeriod = cyc - lastFall;
        lastFall = cyc; fallCount++;
      end
      if (!prevOut && readyOut) lastWidth = cyc - lastFall;
      prevOut = readyOut;
    end
  end

  task automatic doReset(input int pre, input int osr, input bit hiz);
    @(posedge clk); #2;
    rstN = 0; preSel = 2'(pre); osrSel = 2'(osr); hizIdleN = hiz;
    repeat (5) @(posedge clk);
    #2 rstN = 1;
  endtask

  task automatic waitPulse();
    int target = fallCount + 1;
    do begin @(negedge clk); #1; end while (fallCount < target);
    do begin @(negedge clk); #1; end while (!readyOut);
  endtask

  task automatic runConfig(input int pre, input int osr, input bit hiz);
    int p = 1 << pre;
    int l = p * (32 << osr);
    doReset(pre, osr, hiz);
    waitPulse();
    check(firstFall - relCyc == 1 + l - p, "R8", "first strobe offset",
          firstFall - relCyc, 1 + l - p);
    waitPulse();
    waitPulse();
    check(lastWidth == p, "R1", "strobe width (prescale)", lastWidth, p);
    check(lastWidth == p, "R3", "strobe width one modulator period", lastWidth, p);
    check(lastPeriod == l, "R2", "strobe period", lastPeriod, l);
  endtask

  initial begin
    rstN = 1'b1;
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(readyOut === 1'b1 && readyOe === 1'b0, "R6", "initial reset idle",
          int'({readyOut, readyOe}), 2);

    runConfig(0, 0, 1'b1);
    runConfig(2, 1, 1'b1);
    runConfig(1, 0, 1'b0);
    runConfig(3, 3, 1'b0);
    runConfig(2, 0, 1'b1);

    // R5: released idle: enable only during the strobe
    doReset(1, 1, 1'b0);
    @(negedge clk); #1;
    check(readyOe === 1'b0, "R5", "oe released in idle", int'(readyOe), 0);
    do begin @(negedge clk); #1; end while (readyOut);
    check(readyOe === 1'b1, "R5", "oe driven during strobe", int'(readyOe), 1);

    // R7: change settings mid-period; current period keeps old timing
    doReset(0, 0, 1'b1);
    waitPulse();
    repeat (10) @(posedge clk);
    #2 preSel = 2'd2; osrSel = 2'd2;
    waitPulse();
    check(lastWidth == 1, "R7", "width of pulse after mid-period change", lastWidth, 1);
    check(lastPeriod == 32, "R7", "period not cut short", lastPeriod, 32);
    waitPulse();
    check(lastWidth == 4, "R7", "new width after boundary", lastWidth, 4);
    waitPulse();
    check(lastPeriod == 512, "R7", "new period after boundary", lastPeriod, 512);

    // R9: mode bit acts at once
    @(posedge clk); #2 hizIdleN = 1'b0;
    @(negedge clk); #1;
    check(readyOe === 1'b0, "R9", "oe drops with mode bit", int'(readyOe), 0);
    @(posedge clk); #2 hizIdleN = 1'b1;
    @(negedge clk); #1;
    check(readyOe === 1'b1, "R9", "oe returns with mode bit", int'(readyOe), 1);

    // R6: reset in the middle of a strobe releases the pin at once
    do begin @(negedge clk); #1; end while (readyOut);
    @(posedge clk); #2 rstN = 1'b0;
    @(negedge clk); #1;
    check(readyOut === 1'b1, "R6", "out high on mid-strobe reset", int'(readyOut), 1);
    check(readyOe === 1'b0, "R6", "oe low on mid-strobe reset", int'(readyOe), 0);
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    repeat (4) @(posedge clk);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule